// File: doc/BRIEF.md
# Audio Rate-Converter FIFO Front-End

This block is the register-mapped shell around a stereo sample-rate converter. Software pushes 32-bit stereo words through a write-only data port into an input queue. It collects processed words from a read-only data port, which drains a 16-entry output queue. Each word carries two 16-bit channels, with the left channel in the upper half. Control registers set the queue threshold levels, byte-order swapping on either side, channel exchange on the output side and the interrupt enables. They also accept the clear and flush commands. A status register reports both queue occupancies and six event flags. The filtering arithmetic is replaced here by a stub. The stub moves one queued input word to the output queue per cycle while it is allowed to run.

A sequencer drives the stub. It has four states. SQ_IDLE means the module is disabled and nothing moves. SQ_RUN means the module is enabled and words move. SQ_FLUSH means a flush is in progress: words move whether or not the module is enabled, until the input queue is empty. SQ_DRAIN means the flush is done and the sequencer is waiting for software to empty the output queue.

The transitions are:
- IDLE to RUN on enable; RUN to IDLE on disable.
- IDLE, RUN or DRAIN to FLUSH on a flush command.
- FLUSH to DRAIN once the input queue is empty.
- DRAIN to RUN or IDLE, according to the enable bit, once the output queue is empty. This transition raises the conversion-end event.
- A clear command sends any state to IDLE.

Registers are 16 bits wide and use bus_wdata/bus_rdata[15:0]. The byte offsets are:
- 0: input data
- 4: output data
- 8: input control
- 10: output control
- 12: control
- 14: status

Top module: `audio_src_frontend`

## Requirements
- R1: After reset, the status register (offset 14) reads 0x0002 and the control registers at offsets 8, 10 and 12 read 0. A read of offset 0 always returns 0.
- R2: With control bit 12 (enable) set, words written to offset 0 come out of offset 4 in write order. Status bits 10:7 hold the input queue count and bits 15:11 the output queue count.
- R3: The input queue holds 8 words. A write to offset 0 while it is full and not draining is discarded.
- R4: A read of offset 4 while the output queue is empty returns the word returned by the previous read of offset 4. It also sets status bit 3 (underflow). irq_udf equals that flag ANDed with control bit 11.
- R5: When input control bit 9 is set, the two bytes inside each 16-bit channel of an input word are swapped before queuing.
- R6: When output control bit 9 is set, the bytes inside each channel of an output word are swapped. When output control bit 10 is set, the upper and lower channels are exchanged. The two options may be combined.
- R7: The output threshold code in output control bits 1:0 selects 1, 4, 8 or 12 words. Status bit 0 sets when the output count rises to at least that level. irq_out_lvl equals bit 0 ANDed with output control bit 8.
- R8: The input threshold code in input control bits 1:0 selects 0, 2, 4 or 6 words. Status bit 1 sets when the input count falls to at most that level. irq_in_lvl equals bit 1 ANDed with input control bit 8.
- R9: Status flags at bits 0, 1, 2, 3 and 5 are cleared by writing 0 to that bit, but only after the flag has been read as 1. Writing 1 leaves a flag unchanged.
- R10: A word produced while the output queue holds 16 words replaces the newest entry and sets status bit 2 (overwrite). irq_ovw equals that flag ANDed with control bit 10.
- R11: Writing 1 to control bit 8 empties both queues. It also resets the repeated output value to 0.
- R12: Writing 1 to control bit 9 moves every queued input word to the output queue, even while the module is disabled. Status bit 4 stays high until the input queue is empty. Status bit 5 (conversion end) sets once the output queue has then been drained. irq_done equals bit 5 ANDed with control bit 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of offset 4 pops the output queue |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| irq_out_lvl | output | 1 | Output threshold interrupt |
| irq_in_lvl | output | 1 | Input threshold interrupt |
| irq_ovw | output | 1 | Output overwrite interrupt |
| irq_udf | output | 1 | Output underflow interrupt |
| irq_done | output | 1 | Conversion-end interrupt |

## Verification
The hardest case to reach is the overwrite of the newest output entry. It needs 17 words to pass through the stub with no read in between. The input queue holds only 8, so the stimulus enables the module first and then streams the words one per cycle while the stub keeps pace. The flush path is almost as indirect. The module is kept disabled while words are queued, so only the flush command can move them. Reads then empty the output queue, which produces the conversion-end event and lets the DRAIN exit be observed.

// File: rtl/audio_src_pkg.sv
package audio_src_pkg;

    localparam int DATA_W = 32;

    // register byte offsets
    localparam logic [3:0] OFS_IN_DATA  = 4'h0;
    localparam logic [3:0] OFS_OUT_DATA = 4'h4;
    localparam logic [3:0] OFS_IN_CTL   = 4'h8;
    localparam logic [3:0] OFS_OUT_CTL  = 4'hA;
    localparam logic [3:0] OFS_CTL      = 4'hC;
    localparam logic [3:0] OFS_STAT     = 4'hE;

    // sticky flag indices inside the flag bank
    localparam int FL_OUT_LVL = 0;
    localparam int FL_IN_LVL  = 1;
    localparam int FL_OVW     = 2;
    localparam int FL_UDF     = 3;
    localparam int FL_DONE    = 4;
    localparam int N_FLAGS    = 5;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_FLUSH,
        SQ_DRAIN
    } seq_state_t;

    function automatic logic [DATA_W-1:0] swap_lane_bytes(input logic [DATA_W-1:0] w);
        return {w[23:16], w[31:24], w[7:0], w[15:8]};
    endfunction

    function automatic logic [DATA_W-1:0] swap_channels(input logic [DATA_W-1:0] w);
        return {w[15:0], w[31:16]};
    endfunction

    // input level code -> 0, 2, 4, 6
    function automatic logic [3:0] in_level(input logic [1:0] code);
        return {1'b0, code, 1'b0};
    endfunction

    // output level code -> 1, 4, 8, 12
    function automatic logic [4:0] out_level(input logic [1:0] code);
        return (code == 2'd0) ? 5'd1 : {1'b0, code, 2'b00};
    endfunction

endpackage

// File: rtl/src_fifo.sv
module src_fifo #(
    parameter int W           = 32,
    parameter int DEPTH       = 8,
    parameter bit KEEP_NEWEST = 1'b0,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          collide
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign collide = push && full && !do_pop;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (wipe) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    generate
        if (KEEP_NEWEST) begin : g_replace
            always_ff @(posedge clk) begin
                if (do_push)
                    mem[wr_ptr] <= din;
                else if (collide && !wipe)
                    mem[wr_ptr - AW'(1)] <= din;
            end
        end else begin : g_drop
            always_ff @(posedge clk) begin
                if (do_push)
                    mem[wr_ptr] <= din;
            end
        end
    endgenerate

endmodule

// File: rtl/src_seq.sv
module src_seq
    import audio_src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_req,
    input  logic flush_req,
    input  logic run_en,
    input  logic in_empty,
    input  logic out_empty,
    output logic move,
    output logic flushing,
    output logic conv_done
);

    seq_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:  if (flush_req) nxt = SQ_FLUSH;
                      else if (run_en) nxt = SQ_RUN;
            SQ_RUN:   if (flush_req) nxt = SQ_FLUSH;
                      else if (!run_en) nxt = SQ_IDLE;
            SQ_FLUSH: if (in_empty) nxt = SQ_DRAIN;
            SQ_DRAIN: if (flush_req) nxt = SQ_FLUSH;
                      else if (out_empty) nxt = run_en ? SQ_RUN : SQ_IDLE;
            default:  nxt = SQ_IDLE;
        endcase
        if (clear_req) nxt = SQ_IDLE;
    end

    always_comb begin
        move      = 1'b0;
        flushing  = 1'b0;
        conv_done = 1'b0;
        unique case (state)
            SQ_IDLE:  ;
            SQ_RUN:   move = !in_empty && !clear_req;
            SQ_FLUSH: begin
                move     = !in_empty && !clear_req;
                flushing = 1'b1;
            end
            SQ_DRAIN: conv_done = out_empty && !flush_req && !clear_req;
            default:  ;
        endcase
    end

endmodule

// File: rtl/src_flags.sv
module src_flags
    import audio_src_pkg::*;
#(
    parameter int ICW = 4,
    parameter int OCW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ICW-1:0]     in_cnt,
    input  logic [OCW-1:0]     out_cnt,
    input  logic [1:0]         in_code,
    input  logic [1:0]         out_code,
    input  logic               ovw_hit,
    input  logic               udf_hit,
    input  logic               conv_done,
    input  logic               stat_rd,
    input  logic               stat_wr,
    input  logic [N_FLAGS-1:0] keep,
    output logic [N_FLAGS-1:0] flags
);

    localparam logic [N_FLAGS-1:0] FLAG_RST = N_FLAGS'(1) << FL_IN_LVL;

    logic in_cond, out_cond, in_cond_q, out_cond_q;
    logic [N_FLAGS-1:0] set_ev, seen;

    assign in_cond  = (in_cnt <= ICW'(in_level(in_code)));
    assign out_cond = (out_cnt >= OCW'(out_level(out_code)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cond_q  <= 1'b1;
            out_cond_q <= 1'b0;
        end else begin
            in_cond_q  <= in_cond;
            out_cond_q <= out_cond;
        end
    end

    always_comb begin
        set_ev             = '0;
        set_ev[FL_OUT_LVL] = out_cond && !out_cond_q;
        set_ev[FL_IN_LVL]  = in_cond && !in_cond_q;
        set_ev[FL_OVW]     = ovw_hit;
        set_ev[FL_UDF]     = udf_hit;
        set_ev[FL_DONE]    = conv_done;
    end

    generate
        for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[i] <= FLAG_RST[i];
                    seen[i]  <= 1'b0;
                end else if (set_ev[i]) begin
                    flags[i] <= 1'b1;
                end else if (stat_wr && !keep[i] && seen[i]) begin
                    flags[i] <= 1'b0;
                    seen[i]  <= 1'b0;
                end else if (stat_rd && flags[i]) begin
                    seen[i]  <= 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/audio_src_frontend.sv
module audio_src_frontend
    import audio_src_pkg::*;
#(
    parameter int IN_DEPTH  = 8,
    parameter int OUT_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_out_lvl,
    output logic        irq_in_lvl,
    output logic        irq_ovw,
    output logic        irq_udf,
    output logic        irq_done
);

    localparam int ICW = $clog2(IN_DEPTH) + 1;
    localparam int OCW = $clog2(OUT_DEPTH) + 1;

    // control fields
    logic       in_bswap, in_ie;
    logic [1:0] in_code;
    logic       out_xchg, out_bswap, out_ie;
    logic [1:0] out_code;
    logic       ctl_run, ctl_ovw_ie, ctl_udf_ie, ctl_done_ie;

    logic [DATA_W-1:0] last_rd, in_word, in_dout, out_dout, out_view, out_word;
    logic [ICW-1:0]    in_cnt;
    logic [OCW-1:0]    out_cnt;
    logic              in_drop, ovw_hit, move, flushing, conv_done;
    logic [N_FLAGS-1:0] flags, keep;
    logic [15:0]       stat_word;

    // bus decode
    logic wr_in, wr_ictl, wr_octl, wr_ctl, wr_stat, rd_out, rd_stat;
    logic clear_req, flush_req, out_pop, udf_hit;

    assign wr_in     = bus_wr && (bus_addr == OFS_IN_DATA);
    assign wr_ictl   = bus_wr && (bus_addr == OFS_IN_CTL);
    assign wr_octl   = bus_wr && (bus_addr == OFS_OUT_CTL);
    assign wr_ctl    = bus_wr && (bus_addr == OFS_CTL);
    assign wr_stat   = bus_wr && (bus_addr == OFS_STAT);
    assign rd_out    = bus_rd && (bus_addr == OFS_OUT_DATA);
    assign rd_stat   = bus_rd && (bus_addr == OFS_STAT);
    assign clear_req = wr_ctl && bus_wdata[8];
    assign flush_req = wr_ctl && bus_wdata[9];
    assign out_pop   = rd_out && (out_cnt != '0);
    assign udf_hit   = rd_out && (out_cnt == '0);

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_bswap    <= 1'b0;
            in_ie       <= 1'b0;
            in_code     <= 2'd0;
            out_xchg    <= 1'b0;
            out_bswap   <= 1'b0;
            out_ie      <= 1'b0;
            out_code    <= 2'd0;
            ctl_run     <= 1'b0;
            ctl_ovw_ie  <= 1'b0;
            ctl_udf_ie  <= 1'b0;
            ctl_done_ie <= 1'b0;
        end else begin
            if (wr_ictl) begin
                in_bswap <= bus_wdata[9];
                in_ie    <= bus_wdata[8];
                in_code  <= bus_wdata[1:0];
            end
            if (wr_octl) begin
                out_xchg  <= bus_wdata[10];
                out_bswap <= bus_wdata[9];
                out_ie    <= bus_wdata[8];
                out_code  <= bus_wdata[1:0];
            end
            if (wr_ctl) begin
                ctl_done_ie <= bus_wdata[13];
                ctl_run     <= bus_wdata[12];
                ctl_udf_ie  <= bus_wdata[11];
                ctl_ovw_ie  <= bus_wdata[10];
            end
        end
    end

    // data path transforms
    assign in_word = in_bswap ? swap_lane_bytes(bus_wdata) : bus_wdata;

    always_comb begin
        out_view = out_dout;
        if (out_bswap) out_view = swap_lane_bytes(out_view);
        if (out_xchg)  out_view = swap_channels(out_view);
    end

    assign out_word = (out_cnt == '0) ? last_rd : out_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       last_rd <= '0;
        else if (clear_req) last_rd <= '0;
        else if (out_pop) last_rd <= out_view;
    end

    src_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH), .KEEP_NEWEST(1'b0)) u_in_q (
        .clk(clk), .rst_n(rst_n), .wipe(clear_req),
        .push(wr_in), .pop(move), .din(in_word),
        .dout(in_dout), .count(in_cnt), .collide(in_drop)
    );

    src_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH), .KEEP_NEWEST(1'b1)) u_out_q (
        .clk(clk), .rst_n(rst_n), .wipe(clear_req),
        .push(move), .pop(out_pop), .din(in_dout),
        .dout(out_dout), .count(out_cnt), .collide(ovw_hit)
    );

    src_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .clear_req(clear_req), .flush_req(flush_req), .run_en(ctl_run),
        .in_empty(in_cnt == '0), .out_empty(out_cnt == '0),
        .move(move), .flushing(flushing), .conv_done(conv_done)
    );

    always_comb begin
        keep             = '0;
        keep[FL_OUT_LVL] = bus_wdata[0];
        keep[FL_IN_LVL]  = bus_wdata[1];
        keep[FL_OVW]     = bus_wdata[2];
        keep[FL_UDF]     = bus_wdata[3];
        keep[FL_DONE]    = bus_wdata[5];
    end

    src_flags #(.ICW(ICW), .OCW(OCW)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .in_cnt(in_cnt), .out_cnt(out_cnt),
        .in_code(in_code), .out_code(out_code),
        .ovw_hit(ovw_hit), .udf_hit(udf_hit), .conv_done(conv_done),
        .stat_rd(rd_stat), .stat_wr(wr_stat), .keep(keep),
        .flags(flags)
    );

    assign stat_word = {5'(out_cnt), 4'(in_cnt), 1'b0, flags[FL_DONE], flushing,
                        flags[FL_UDF], flags[FL_OVW], flags[FL_IN_LVL], flags[FL_OUT_LVL]};

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_OUT_DATA: bus_rdata = out_word;
            OFS_IN_CTL:   bus_rdata = {16'b0, 6'b0, in_bswap, in_ie, 6'b0, in_code};
            OFS_OUT_CTL:  bus_rdata = {16'b0, 5'b0, out_xchg, out_bswap, out_ie, 6'b0, out_code};
            OFS_CTL:      bus_rdata = {16'b0, 2'b0, ctl_done_ie, ctl_run, ctl_udf_ie, ctl_ovw_ie, 10'b0};
            OFS_STAT:     bus_rdata = {16'b0, stat_word};
            default:      bus_rdata = '0;
        endcase
    end

    assign irq_out_lvl = flags[FL_OUT_LVL] && out_ie;
    assign irq_in_lvl  = flags[FL_IN_LVL] && in_ie;
    assign irq_ovw     = flags[FL_OVW] && ctl_ovw_ie;
    assign irq_udf     = flags[FL_UDF] && ctl_udf_ie;
    assign irq_done    = flags[FL_DONE] && ctl_done_ie;

endmodule

// File: rtl/src_frontend_chk.sv
module src_frontend_chk #(
    parameter int IN_DEPTH  = 8,
    parameter int OUT_DEPTH = 16,
    localparam int ICW = $clog2(IN_DEPTH) + 1,
    localparam int OCW = $clog2(OUT_DEPTH) + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [3:0]     bus_addr,
    input logic [31:0]    bus_wdata,
    input logic [31:0]    bus_rdata,
    input logic [ICW-1:0] in_cnt,
    input logic [OCW-1:0] out_cnt,
    input logic           in_drop,
    input logic           flushing
);

    a_r3_in_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_cnt <= ICW'(IN_DEPTH));

    a_r3_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        in_drop |-> in_cnt == ICW'(IN_DEPTH));

    a_r10_out_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= OCW'(OUT_DEPTH));

    a_r1_in_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'h0) |-> bus_rdata == 32'h0);

    a_r4_repeat_last: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'h4 && out_cnt == '0 &&
         $past(bus_rd && !bus_wr && bus_addr == 4'h4))
        |-> bus_rdata == $past(bus_rdata));

    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == 4'hC && bus_wdata[8])
        |-> (in_cnt == '0 && out_cnt == '0));

    a_r12_flush_ends_dry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flushing) |-> in_cnt == '0);

endmodule

bind audio_src_frontend src_frontend_chk #(
    .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_cnt(in_cnt), .out_cnt(out_cnt), .in_drop(in_drop), .flushing(flushing)
);

// File: tb/audio_src_frontend_test.sv
module audio_src_frontend_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq_out_lvl, irq_in_lvl, irq_ovw, irq_udf, irq_done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    audio_src_frontend uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out_lvl(irq_out_lvl), .irq_in_lvl(irq_in_lvl), .irq_ovw(irq_ovw),
        .irq_udf(irq_udf), .irq_done(irq_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic bw(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_flags();
        logic [31:0] v;
        br(4'hE, v);
        bw(4'hE, 32'h0);
    endtask

    function automatic logic [31:0] in_n(input logic [31:0] s);  return (s >> 7) & 32'hF;  endfunction
    function automatic logic [31:0] out_n(input logic [31:0] s); return (s >> 11) & 32'h1F; endfunction

    task automatic t_reset();
        logic [31:0] v;
        br(4'h0, v); check("R1 input port reads zero", v, 32'h0);
        br(4'h8, v); check("R1 input control reset", v, 32'h0);
        br(4'hA, v); check("R1 output control reset", v, 32'h0);
        br(4'hC, v); check("R1 control reset", v, 32'h0);
        br(4'hE, v); check("R1 status reset", v, 32'h0002);
    endtask

    task automatic t_pass();
        logic [31:0] v;
        bw(4'hC, 32'h1000);
        bw(4'h0, 32'hA0A0_0001);
        bw(4'h0, 32'hB0B0_0002);
        bw(4'h0, 32'hC0C0_0003);
        idle(2);
        br(4'hE, v);
        check("R2 output count", out_n(v), 32'd3);
        check("R2 input count", in_n(v), 32'd0);
        br(4'h4, v); check("R2 first word", v, 32'hA0A0_0001);
        br(4'h4, v); check("R2 second word", v, 32'hB0B0_0002);
        br(4'h4, v); check("R2 third word", v, 32'hC0C0_0003);
        br(4'h0, v); check("R1 input port still zero", v, 32'h0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        clr_flags();
        bw(4'hC, 32'h1800);
        br(4'h4, v); check("R4 empty read repeats", v, 32'hC0C0_0003);
        br(4'hE, v); check("R4 underflow flag", (v >> 3) & 1, 32'd1);
        check("R4 underflow irq", {31'b0, irq_udf}, 32'd1);
        br(4'h4, v); check("R4 repeat again", v, 32'hC0C0_0003);
    endtask

    task automatic t_clear_rule();
        logic [31:0] v;
        clr_flags();
        br(4'h4, v);
        bw(4'hE, 32'h0);
        br(4'hE, v); check("R9 unread flag survives write 0", (v >> 3) & 1, 32'd1);
        bw(4'hE, 32'h0);
        br(4'hE, v); check("R9 read flag cleared by write 0", (v >> 3) & 1, 32'd0);
    endtask

    task automatic t_swaps();
        logic [31:0] v;
        bw(4'h8, 32'h0200);
        bw(4'h0, 32'h1122_3344); idle(2);
        br(4'h4, v); check("R5 input byte swap", v, 32'h2211_4433);
        bw(4'h8, 32'h0);
        bw(4'hA, 32'h0400);
        bw(4'h0, 32'hAAAA_5555); idle(2);
        br(4'h4, v); check("R6 channel exchange", v, 32'h5555_AAAA);
        bw(4'hA, 32'h0600);
        bw(4'h0, 32'h1122_3344); idle(2);
        br(4'h4, v); check("R6 swap plus exchange", v, 32'h4433_2211);
        bw(4'hA, 32'h0200);
        bw(4'h0, 32'h1122_3344); idle(2);
        br(4'h4, v); check("R6 output byte swap", v, 32'h2211_4433);
        bw(4'hA, 32'h0);
    endtask

    task automatic t_in_full();
        logic [31:0] v;
        bw(4'hC, 32'h0);
        for (int i = 0; i < 9; i++) bw(4'h0, 32'h100 + i);
        br(4'hE, v); check("R3 input count capped", in_n(v), 32'd8);
        bw(4'hC, 32'h1000);
        idle(12);
        br(4'hE, v); check("R3 eight words moved", out_n(v), 32'd8);
        for (int i = 0; i < 8; i++) begin
            br(4'h4, v); check("R3 kept word", v, 32'h100 + i);
        end
        br(4'hE, v); check("R3 ninth word dropped", out_n(v), 32'd0);
    endtask

    task automatic t_out_level();
        logic [31:0] v;
        bw(4'hC, 32'h0);
        bw(4'hA, 32'h0101);
        clr_flags();
        for (int i = 0; i < 3; i++) bw(4'h0, 32'h400 + i);
        bw(4'hC, 32'h1000);
        idle(5);
        br(4'hE, v); check("R7 below level no flag", v & 1, 32'd0);
        check("R7 irq low below level", {31'b0, irq_out_lvl}, 32'd0);
        bw(4'h0, 32'h403);
        idle(3);
        br(4'hE, v); check("R7 flag at level 4", v & 1, 32'd1);
        check("R7 irq high", {31'b0, irq_out_lvl}, 32'd1);
        bw(4'hA, 32'h0001);
        check("R7 irq gated by enable", {31'b0, irq_out_lvl}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            br(4'h4, v); check("R7 drained word", v, 32'h400 + i);
        end
        bw(4'hA, 32'h0);
    endtask

    task automatic t_in_level();
        logic [31:0] v;
        bw(4'hC, 32'h0);
        bw(4'h8, 32'h0101);
        for (int i = 0; i < 3; i++) bw(4'h0, 32'h500 + i);
        clr_flags();
        check("R8 irq low above level", {31'b0, irq_in_lvl}, 32'd0);
        bw(4'hC, 32'h1000);
        idle(5);
        br(4'hE, v); check("R8 flag when count falls to 2", (v >> 1) & 1, 32'd1);
        check("R8 irq high", {31'b0, irq_in_lvl}, 32'd1);
        for (int i = 0; i < 3; i++) begin
            br(4'h4, v); check("R8 drained word", v, 32'h500 + i);
        end
        bw(4'h8, 32'h0);
    endtask

    task automatic t_overwrite();
        logic [31:0] v;
        clr_flags();
        bw(4'hC, 32'h1400);
        for (int i = 0; i < 17; i++) bw(4'h0, 32'h200 + i);
        idle(4);
        br(4'hE, v);
        check("R10 output full", out_n(v), 32'd16);
        check("R10 overwrite flag", (v >> 2) & 1, 32'd1);
        check("R10 overwrite irq", {31'b0, irq_ovw}, 32'd1);
        for (int i = 0; i < 16; i++) begin
            br(4'h4, v);
            check("R10 queue order", v, (i < 15) ? 32'h200 + i : 32'h210);
        end
    endtask

    task automatic t_clear();
        logic [31:0] v;
        bw(4'hC, 32'h1000);
        bw(4'h0, 32'h600); bw(4'h0, 32'h601);
        idle(2);
        bw(4'hC, 32'h0);
        for (int i = 0; i < 3; i++) bw(4'h0, 32'h610 + i);
        br(4'hE, v);
        check("R11 pre-clear in count", in_n(v), 32'd3);
        check("R11 pre-clear out count", out_n(v), 32'd2);
        bw(4'hC, 32'h0100);
        br(4'hE, v);
        check("R11 in count cleared", in_n(v), 32'd0);
        check("R11 out count cleared", out_n(v), 32'd0);
        br(4'h4, v); check("R11 repeat value reset", v, 32'h0);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        clr_flags();
        bw(4'hC, 32'h2000);
        for (int i = 0; i < 3; i++) bw(4'h0, 32'h300 + i);
        bw(4'hC, 32'h2200);
        br(4'hE, v); check("R12 flush flag high", (v >> 4) & 1, 32'd1);
        idle(6);
        br(4'hE, v);
        check("R12 flush flag low", (v >> 4) & 1, 32'd0);
        check("R12 no end before drain", (v >> 5) & 1, 32'd0);
        check("R12 words flushed", out_n(v), 32'd3);
        check("R12 irq low before drain", {31'b0, irq_done}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            br(4'h4, v); check("R12 flushed word", v, 32'h300 + i);
        end
        idle(2);
        br(4'hE, v); check("R12 conversion end flag", (v >> 5) & 1, 32'd1);
        check("R12 conversion end irq", {31'b0, irq_done}, 32'd1);
    endtask

    initial begin
        #(8 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_underflow();
        t_clear_rule();
        t_swaps();
        t_in_full();
        t_out_level();
        t_in_level();
        t_overwrite();
        t_clear();
        t_flush();
        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule